// File: doc/BRIEF.md
# DMA Transfer Strobe Qualifier

This block sits between the acknowledge pins of a shared 32-bit DMA data port and the four FIFOs behind it. It looks at four port channels: compress-in, decompress-in, compress-out and decompress-out. Each channel has an active-low acknowledge. The block also sees one shared data-strobe line. On every rising clock edge it decides whether a word moves, and if so on which channel. The result is a write strobe for one of the two input FIFOs or a read strobe for one of the two output FIFOs.

A 4-bit strobe-condition code picks the qualifying equation. The equation uses the present acknowledge and strobe values, the same values registered one clock earlier, or a mix of both. The equation is chosen by code bits [2:1]. Bit 0 sets the polarity of the strobe line, and bit 3 must be 0 for any transfer to be qualified.

The strobes are combinational within the cycle, so a FIFO captures the word on the edge where the strobe is high. When more than one acknowledge is active at the same time, the block issues no strobes and raises a sticky collision flag.

Top module: `dsq_strobe_qualifier`

## Requirements
- R1: When strobe_code[3] is 1, all four strobe outputs stay low whatever the acknowledges and the strobe line do.
- R2: With strobe_code[3:1] = 000, channel c strobes when its acknowledge is active now, its acknowledge was active in the previous cycle, and the strobe line is asserted now.
- R3: With strobe_code[3:1] = 001, channel c strobes when its acknowledge is active now and the strobe line is asserted now.
- R4: With strobe_code[3:1] = 010, channel c strobes when its acknowledge was active in the previous cycle and the strobe line was asserted in the previous cycle. The present values are not used.
- R5: With strobe_code[3:1] = 011, channel c strobes when its acknowledge is active both now and in the previous cycle. The strobe line has no effect.
- R6: Strobe polarity follows strobe_code[0]. With 0, the line is asserted when high. With 1, it is asserted when low, and this includes the previous-cycle value in the 010 group.
- R7: Channel index equals the ack_n bit position. Channels 0 and 1 drive in_wr_stb[0] and in_wr_stb[1]. Channels 2 and 3 drive out_rd_stb[0] and out_rd_stb[1]. At most one of the four strobes is high in any cycle.
- R8: No strobe is issued in a cycle where two or more acknowledges are active, nor in the cycle right after such a cycle.
- R9: collision rises on the edge after a cycle with two or more active acknowledges. It then stays high until an edge where clr_collision is 1 and no new collision occurs. A new collision takes priority over the clear.
- R10: A synchronous active-high reset clears the previous-cycle history and the collision flag. Right after reset, with no acknowledge active, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| strobe_code | input | 4 | Strobe-condition code |
| ack_n | input | 4 | Active-low acknowledges, bit = channel index |
| sd | input | 1 | Shared data-strobe line |
| clr_collision | input | 1 | Clears the sticky collision flag |
| in_wr_stb | output | 2 | Write strobes, compress-in and decompress-in FIFOs |
| out_rd_stb | output | 2 | Read strobes, compress-out and decompress-out FIFOs |
| collision | output | 1 | Sticky multiple-acknowledge flag |

## Verification
The strobe outputs are due in the same cycle as the inputs that qualify them. They also depend on history captured at the previous rising edge. For this reason the bench changes the inputs at the falling edge and compares the strobes shortly afterwards, before the next rising edge, against a model that keeps its own copy of the last cycle's acknowledges, strobe line and collision state. The collision flag is due one edge after the collision, so the bench compares it against the model state held from before that edge. The bench then updates the model after the comparison. Every one of the sixteen codes is swept over several dozen cycles of mixed one-hot, idle and colliding acknowledge patterns.

// File: rtl/dsq_pkg.sv
package dsq_pkg;

    localparam int NUM_IN  = 2;
    localparam int NUM_OUT = 2;
    localparam int NUM_CH  = NUM_IN + NUM_OUT;
    localparam int CODE_W  = 4;

    // equation group selected by code bits [2:1]
    typedef enum logic [1:0] {
        GRP_NOW_HIST_SD = 2'b00,
        GRP_NOW_SD      = 2'b01,
        GRP_HIST_ONLY   = 2'b10,
        GRP_NOW_HIST    = 2'b11
    } eq_grp_e;

    typedef struct packed {
        logic    dma_en;   // code[3] == 0
        eq_grp_e grp;      // code[2:1]
        logic    sd_low;   // code[0]: strobe line active low
    } code_cfg_t;

    typedef struct packed {
        logic ack;   // acknowledge active (true level)
        logic sd;    // raw strobe line
    } ch_sample_t;

    function automatic code_cfg_t decode_code(input logic [CODE_W-1:0] code);
        code_cfg_t c;
        c.dma_en = ~code[3];
        c.grp    = eq_grp_e'(code[2:1]);
        c.sd_low = code[0];
        return c;
    endfunction

    function automatic logic sd_asserted(input logic raw, input logic low_active);
        return low_active ? ~raw : raw;
    endfunction

    function automatic logic qualify(input eq_grp_e grp,
                                     input logic ack_now, input logic ack_hist,
                                     input logic sd_now, input logic sd_hist);
        logic r;
        unique case (grp)
            GRP_NOW_HIST_SD: r = ack_now & ack_hist & sd_now;
            GRP_NOW_SD:      r = ack_now & sd_now;
            GRP_HIST_ONLY:   r = ack_hist & sd_hist;
            GRP_NOW_HIST:    r = ack_now & ack_hist;
            default:         r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/dsq_history.sv
module dsq_history
    import dsq_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic                  clk,
    input  logic                  rst,
    input  ch_sample_t [CH-1:0]   now_s,
    output ch_sample_t [CH-1:0]   hist_s
);

    generate
        for (genvar c = 0; c < CH; c++) begin : g_ch
            ch_sample_t q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q <= '0;
                end else begin
                    q <= now_s[c];
                end
            end
            assign hist_s[c] = q;

            AST_HIST_TRACK: assert property (@(posedge clk) disable iff (rst)
                !$past(rst) |-> hist_s[c].ack == $past(now_s[c].ack)); // R10
        end
    endgenerate

endmodule

// File: rtl/dsq_chan_eval.sv
module dsq_chan_eval
    import dsq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  code_cfg_t  cfg,
    input  ch_sample_t now_s,
    input  ch_sample_t hist_s,
    input  logic       quiet,
    output logic       stb
);

    logic sd_now_act;
    logic sd_hist_act;
    logic raw_hit;

    always_comb begin
        sd_now_act  = sd_asserted(now_s.sd,  cfg.sd_low);
        sd_hist_act = sd_asserted(hist_s.sd, cfg.sd_low);
        raw_hit     = qualify(cfg.grp, now_s.ack, hist_s.ack, sd_now_act, sd_hist_act);
        stb         = cfg.dma_en & ~quiet & raw_hit;
    end

    AST_GRP0_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (stb && cfg.grp == GRP_NOW_HIST_SD) |-> now_s.ack && $past(now_s.ack)); // R2
    AST_GRP1_NEEDS_ACK: assert property (@(posedge clk) disable iff (rst)
        (stb && cfg.grp == GRP_NOW_SD) |-> now_s.ack); // R3
    AST_GRP2_NEEDS_PAST: assert property (@(posedge clk) disable iff (rst)
        (stb && cfg.grp == GRP_HIST_ONLY) |-> $past(now_s.ack)); // R4
    AST_GRP3_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
        (stb && cfg.grp == GRP_NOW_HIST) |-> now_s.ack && $past(now_s.ack)); // R5

endmodule

// File: rtl/dsq_collision.sv
module dsq_collision
    import dsq_pkg::*;
#(
    parameter int CH = NUM_CH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [CH-1:0] ack,
    input  logic          clr,
    output logic          multi_now,
    output logic          multi_prev,
    output logic          flag
);

    localparam int CNT_W = $clog2(CH + 1);

    logic [CNT_W-1:0] active_cnt;

    always_comb begin
        active_cnt = '0;
        for (int i = 0; i < CH; i++) begin
            active_cnt = active_cnt + CNT_W'(ack[i]);
        end
        multi_now = (active_cnt > CNT_W'(1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            multi_prev <= 1'b0;
            flag       <= 1'b0;
        end else begin
            multi_prev <= multi_now;
            if (multi_now) begin
                flag <= 1'b1;
            end else if (clr) begin
                flag <= 1'b0;
            end
        end
    end

    AST_FLAG_SETS: assert property (@(posedge clk) disable iff (rst)
        $countones(ack) > 1 |=> flag); // R9
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag); // R9
    AST_FLAG_ONLY_CAUSED: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> $past($countones(ack) > 1)); // R9

endmodule

// File: rtl/dsq_strobe_qualifier.sv
module dsq_strobe_qualifier
    import dsq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] strobe_code,
    input  logic [NUM_CH-1:0] ack_n,
    input  logic              sd,
    input  logic              clr_collision,
    output logic [NUM_IN-1:0] in_wr_stb,
    output logic [NUM_OUT-1:0] out_rd_stb,
    output logic              collision
);

    code_cfg_t               cfg;
    ch_sample_t [NUM_CH-1:0] now_s;
    ch_sample_t [NUM_CH-1:0] hist_s;
    logic [NUM_CH-1:0]       ack;
    logic [NUM_CH-1:0]       ch_stb;
    logic                    multi_now;
    logic                    multi_prev;
    logic                    quiet;

    assign cfg   = decode_code(strobe_code);
    assign ack   = ~ack_n;
    assign quiet = multi_now | multi_prev;

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_smp
            assign now_s[c].ack = ack[c];
            assign now_s[c].sd  = sd;
        end
    endgenerate

    dsq_history #(.CH(NUM_CH)) u_hist (
        .clk    (clk),
        .rst    (rst),
        .now_s  (now_s),
        .hist_s (hist_s)
    );

    dsq_collision #(.CH(NUM_CH)) u_coll (
        .clk        (clk),
        .rst        (rst),
        .ack        (ack),
        .clr        (clr_collision),
        .multi_now  (multi_now),
        .multi_prev (multi_prev),
        .flag       (collision)
    );

    generate
        for (genvar c = 0; c < NUM_CH; c++) begin : g_eval
            dsq_chan_eval u_eval (
                .clk    (clk),
                .rst    (rst),
                .cfg    (cfg),
                .now_s  (now_s[c]),
                .hist_s (hist_s[c]),
                .quiet  (quiet),
                .stb    (ch_stb[c])
            );
        end
    endgenerate

    assign in_wr_stb  = ch_stb[NUM_IN-1:0];
    assign out_rd_stb = ch_stb[NUM_CH-1:NUM_IN];

    AST_NO_STB_NON_DMA: assert property (@(posedge clk) disable iff (rst)
        strobe_code[3] |-> ({out_rd_stb, in_wr_stb} == '0)); // R1
    AST_STB_ONEHOT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({out_rd_stb, in_wr_stb})); // R7
    AST_COLL_QUIET: assert property (@(posedge clk) disable iff (rst)
        $countones(~ack_n) > 1 |-> ({out_rd_stb, in_wr_stb} == '0)); // R8
    AST_GRP3_SD_FREE: assert property (@(posedge clk) disable iff (rst)
        (strobe_code[3:1] == 3'b011 && !ack_n[0] && !$past(ack_n[0])
         && $countones(~ack_n) == 1 && $countones(~$past(ack_n)) == 1)
        |-> in_wr_stb[0]); // R5

endmodule

// File: tb/dsq_strobe_qualifier_bench.sv
module dsq_strobe_qualifier_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] strobe_code = 4'd0;
    logic [3:0] ack_n = 4'hF;
    logic       sd = 1'b0;
    logic       clr_collision = 1'b0;
    logic [1:0] in_wr_stb;
    logic [1:0] out_rd_stb;
    logic       collision;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    dsq_strobe_qualifier u_dsq_strobe_qualifier (
        .clk           (clk),
        .rst           (rst),
        .strobe_code   (strobe_code),
        .ack_n         (ack_n),
        .sd            (sd),
        .clr_collision (clr_collision),
        .in_wr_stb     (in_wr_stb),
        .out_rd_stb    (out_rd_stb),
        .collision     (collision)
    );

    // model state
    logic [3:0] m_prev_ack  = 4'b0;
    logic       m_prev_sd   = 1'b0;
    logic       m_prev_multi = 1'b0;
    logic       m_flag      = 1'b0;
    logic [15:0] lfsr       = 16'hACE1;

    function automatic string req_of(input logic [3:0] code);
        if (code[3]) return "R1";
        case (code[2:1])
            2'd0: return code[0] ? "R2/R6" : "R2";
            2'd1: return code[0] ? "R3/R6" : "R3";
            2'd2: return code[0] ? "R4/R6" : "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic logic [3:0] expect_stb(input logic [3:0] code, input logic [3:0] a,
                                              input logic s, input logic [3:0] pa,
                                              input logic ps, input logic pm);
        logic [3:0] r;
        logic sa, psa;
        int n;
        n = 0;
        for (int i = 0; i < 4; i++) n += a[i];
        sa  = code[0] ? !s  : s;
        psa = code[0] ? !ps : ps;
        r = 4'b0;
        if (!code[3] && n <= 1 && !pm) begin
            for (int i = 0; i < 4; i++) begin
                case (code[2:1])
                    2'd0: r[i] = a[i] && pa[i] && sa;
                    2'd1: r[i] = a[i] && sa;
                    2'd2: r[i] = pa[i] && psa;
                    default: r[i] = a[i] && pa[i];
                endcase
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic step_and_check();
        logic [3:0] a;
        logic [3:0] e;
        logic multi;
        a = ~ack_n;
        #1;
        e = expect_stb(strobe_code, a, sd, m_prev_ack, m_prev_sd, m_prev_multi);
        // R7: channel 0/1 -> in_wr_stb, 2/3 -> out_rd_stb
        check({req_of(strobe_code), "/R7 in_wr_stb"}, 32'(in_wr_stb), 32'(e[1:0]));
        check({req_of(strobe_code), "/R7 out_rd_stb"}, 32'(out_rd_stb), 32'(e[3:2]));
        check("R9 collision", 32'(collision), 32'(m_flag));
        multi = ($countones(a) > 1);
        if (multi) check("R8 quiet", 32'({out_rd_stb, in_wr_stb}), 32'd0);
        m_flag       = multi | (m_flag & !clr_collision);
        m_prev_ack   = a;
        m_prev_sd    = sd;
        m_prev_multi = multi;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10: reset state
        #1;
        check("R10 reset in_wr_stb", 32'(in_wr_stb), 32'd0);
        check("R10 reset out_rd_stb", 32'(out_rd_stb), 32'd0);
        check("R10 reset collision", 32'(collision), 32'd0);
        // directed R9: collision then clear, with set over clear
        @(negedge clk); strobe_code = 4'b0010; ack_n = 4'b1100; clr_collision = 1'b1; step_and_check();
        @(negedge clk); ack_n = 4'hF; clr_collision = 1'b0; step_and_check();
        @(negedge clk); step_and_check();
        @(negedge clk); clr_collision = 1'b1; step_and_check();
        @(negedge clk); clr_collision = 1'b0; step_and_check();
        // sweep all codes
        for (int code = 0; code < 16; code++) begin
            for (int k = 0; k < 48; k++) begin
                @(negedge clk);
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                strobe_code = 4'(code);
                case (lfsr[2:0])
                    3'd0, 3'd1, 3'd2, 3'd3: ack_n = ~(4'b1 << lfsr[1:0]);
                    3'd4, 3'd5: ack_n = ~(4'b1 << lfsr[4:3]);
                    3'd6: ack_n = 4'hF;
                    default: ack_n = ~((4'b1 << lfsr[4:3]) | (4'b1 << 2'(lfsr[4:3] + 2'd1)));
                endcase
                if (lfsr[9:7] == 3'd1) ack_n = m_prev_ack == 4'b0 ? 4'b1110 : ~m_prev_ack;
                sd = lfsr[5];
                clr_collision = (lfsr[8:6] == 3'd0);
                step_and_check();
            end
        end
        @(negedge clk);
        ack_n = 4'hF;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule